// File: doc/BRIEF.md
# Memory-Mapped Histogram Engine

This block counts how many single-precision samples in a memory buffer fall into each of a set of bins. A command arrives on a stream input. It carries three byte addresses: the sample buffer, the bin-edge buffer and the count buffer. It also carries the sample count and the bin count. The engine first checks both counts. If they are valid, it reads the edges and then the samples through one burst-capable memory master. It sorts every sample into a bin, writes the counts back through the same master, and returns a 32-bit status word on a stream output.

A caller places the samples and edges in shared memory and sends one command. It then waits for the status. The engine handles one command at a time and holds its command input stalled until the status word has been taken. Floats are ordered by turning each bit pattern into an unsigned key that keeps the numeric order, so no floating-point arithmetic is needed.

Top module: `hist_accel`

## Requirements
- R1: `cmd_ready` is high only while the engine is idle. It drops in the cycle after a command is accepted and stays low until the status word has been taken. A command request, a response and a memory address request never appear together.
- R2: A command with sample count 0 or above 4096 returns status 1 in the cycle after it is accepted. No address request is issued on either memory channel.
- R3: A command with a valid sample count and a bin count below 2 or above 64 returns status 2 in the cycle after it is accepted, with no memory traffic. When both counts are invalid, status 1 is returned.
- R4: A valid command reads exactly nbins-1 words starting at the edge address, then exactly ndata words starting at the sample address.
- R5: A sample below the first edge counts in bin 0. A sample at or above the last edge counts in bin nbins-1. Any other sample counts in bin i, where edge i-1 <= sample < edge i. A sample equal to an edge goes to the upper bin. The edges are non-decreasing.
- R6: Negative and positive values compare in true numeric order. A NaN sample (exponent all ones, mantissa non-zero) counts in bin nbins-1.
- R7: Exactly nbins words are written starting at the count address. Each word is a count zero-extended to 32 bits, in bin order. The word after the last count is left untouched.
- R8: All counts start from zero for every accepted command. Repeating a command yields the same counts.
- R9: Every read or write burst has at most 16 beats and stays inside one 4 KB page. Address requests hold their address and length until accepted. `w_last` marks the final data beat of a write burst.
- R10: A successful command returns status 0 in the cycle after the handshake of its last write response.
- R11: A non-zero `r_resp` or `b_resp` aborts the command with status 3. A failed read burst is drained to its last beat. No further bursts follow, and a read failure issues no writes.
- R12: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready |
| cmd_data | input | 128 | [31:0] sample address, [63:32] edge address, [95:64] count address, [111:96] ndata, [127:112] nbins |
| rsp_valid | output | 1 | Status stream valid |
| rsp_ready | input | 1 | Status stream ready |
| rsp_data | output | 32 | Status code: 0 ok, 1 bad ndata, 2 bad nbins, 3 memory error |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | output | 32 | Read burst byte address |
| ar_len | output | 8 | Read burst beats minus one |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data ready |
| r_data | input | 32 | Read data word |
| r_resp | input | 2 | Read response, non-zero is an error |
| r_last | input | 1 | Final beat of a read burst |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | 32 | Write burst byte address |
| aw_len | output | 8 | Write burst beats minus one |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | output | 32 | Write data word |
| w_last | output | 1 | Final beat of a write burst |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response ready |
| b_resp | input | 2 | Write response, non-zero is an error |

## Verification
A rejected command has its status due one cycle after the command handshake. A successful command has its status due one cycle after the last write-response handshake. The bench stamps both handshakes with a cycle counter at the clock edge. It then confirms that the status first appears exactly one cycle later, sampling on the falling edge. Counts are checked in the bench memory once the status has been taken, because every write has landed by then. Burst sizes, page crossings and beat totals are tallied per command from the handshakes seen at the memory model.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_AR, S_RD_R, S_WR_AW, S_WR_W, S_WR_B, S_RSP
  } hist_state_e;

  typedef struct packed {
    logic [15:0] nbins;
    logic [15:0] ndata;
    logic [31:0] cnt_addr;
    logic [31:0] edge_addr;
    logic [31:0] smp_addr;
  } hist_cmd_t;

  localparam logic [1:0] ST_OK       = 2'd0;
  localparam logic [1:0] ST_BAD_LEN  = 2'd1;
  localparam logic [1:0] ST_BAD_BINS = 2'd2;
  localparam logic [1:0] ST_BUS_ERR  = 2'd3;

  // Unsigned key whose integer order matches the float order
  function automatic logic [31:0] f32_key(input logic [31:0] v);
    return v[31] ? ~v : (v ^ 32'h8000_0000);
  endfunction

  function automatic logic f32_is_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
  endfunction

endpackage

// File: rtl/hist_burst_len.sv
module hist_burst_len #(
  parameter int MAX_BURST = 16,
  parameter int LEN_W     = 16,
  localparam int BEAT_W   = $clog2(MAX_BURST + 1)
) (
  input  logic [9:0]        page_word,
  input  logic [LEN_W-1:0]  remain,
  output logic [BEAT_W-1:0] beats
);
  localparam logic [LEN_W-1:0] MB = LEN_W'(MAX_BURST);

  logic [LEN_W-1:0] to_page;
  logic [LEN_W-1:0] capped;
  logic [LEN_W-1:0] pick;

  always_comb begin
    to_page = LEN_W'(11'd1024 - {1'b0, page_word});
    capped  = (remain < MB) ? remain : MB;
    pick    = (capped < to_page) ? capped : to_page;
    beats   = BEAT_W'(pick);
  end
endmodule

// File: rtl/hist_binner.sv
module hist_binner
  import hist_pkg::*;
#(
  parameter int MAX_BINS = 64,
  localparam int BIN_W   = $clog2(MAX_BINS),
  localparam int NE      = MAX_BINS - 1
) (
  input  logic [31:0]      sample,
  input  logic [31:0]      edges [NE],
  input  logic [BIN_W-1:0] n_edges,
  output logic [BIN_W-1:0] bin
);
  logic [31:0] skey;
  logic [NE-1:0] passed;

  assign skey = f32_key(sample);

  for (genvar i = 0; i < NE; i++) begin : g_cmp
    assign passed[i] = (BIN_W'(i) < n_edges) && (f32_key(edges[i]) <= skey);
  end

  assign bin = f32_is_nan(sample) ? n_edges : BIN_W'($countones(passed));
endmodule

// File: rtl/hist_accel.sv
module hist_accel
  import hist_pkg::*;
#(
  parameter int MAX_NDATA = 4096,
  parameter int MAX_BINS  = 64,
  parameter int MAX_BURST = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [127:0] cmd_data,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [31:0]  rsp_data,
  output logic         ar_valid,
  input  logic         ar_ready,
  output logic [31:0]  ar_addr,
  output logic [7:0]   ar_len,
  input  logic         r_valid,
  output logic         r_ready,
  input  logic [31:0]  r_data,
  input  logic [1:0]   r_resp,
  input  logic         r_last,
  output logic         aw_valid,
  input  logic         aw_ready,
  output logic [31:0]  aw_addr,
  output logic [7:0]   aw_len,
  output logic         w_valid,
  input  logic         w_ready,
  output logic [31:0]  w_data,
  output logic         w_last,
  input  logic         b_valid,
  output logic         b_ready,
  input  logic [1:0]   b_resp
);
  localparam int LEN_W  = 16;
  localparam int CNT_W  = $clog2(MAX_NDATA + 1);
  localparam int BIN_W  = $clog2(MAX_BINS);
  localparam int BEAT_W = $clog2(MAX_BURST + 1);
  localparam logic [LEN_W-1:0] LIM_N = LEN_W'(MAX_NDATA);
  localparam logic [LEN_W-1:0] LIM_B = LEN_W'(MAX_BINS);

  hist_state_e state_q, state_d;
  hist_cmd_t   cmd;

  logic [31:0]       addr_q, smp_addr_q, cnt_addr_q;
  logic [LEN_W-1:0]  remain_q, ndata_q;
  logic [BIN_W:0]    nbins_q;
  logic [BIN_W-1:0]  idx_q, n_edges, bin;
  logic [BEAT_W-1:0] beats_q, blen;
  logic              edge_ph_q, err_q;
  logic [1:0]        code_q;
  logic [31:0]       edges_q [MAX_BINS-1];
  logic [CNT_W-1:0]  cnt_q   [MAX_BINS];

  logic acc, ar_hs, aw_hs, rbeat, wbeat, bhs, bad_len, bad_bins, rd_fail;

  assign cmd      = hist_cmd_t'(cmd_data);
  assign acc      = cmd_valid && cmd_ready;
  assign ar_hs    = ar_valid && ar_ready;
  assign aw_hs    = aw_valid && aw_ready;
  assign rbeat    = r_valid && r_ready;
  assign wbeat    = w_valid && w_ready;
  assign bhs      = b_valid && b_ready;
  assign bad_len  = (cmd.ndata == '0) || (cmd.ndata > LIM_N);
  assign bad_bins = (cmd.nbins < LEN_W'(2)) || (cmd.nbins > LIM_B);
  assign rd_fail  = err_q || (r_resp != 2'd0);
  assign n_edges  = BIN_W'(nbins_q - 1'b1);

  hist_burst_len #(.MAX_BURST(MAX_BURST), .LEN_W(LEN_W)) u_blen (
    .page_word (addr_q[11:2]),
    .remain    (remain_q),
    .beats     (blen)
  );

  hist_binner #(.MAX_BINS(MAX_BINS)) u_bin (
    .sample  (r_data),
    .edges   (edges_q),
    .n_edges (n_edges),
    .bin     (bin)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (acc) state_d = (bad_len || bad_bins) ? S_RSP : S_RD_AR;
      S_RD_AR: if (ar_hs) state_d = S_RD_R;
      S_RD_R:
        if (rbeat && r_last) begin
          if (rd_fail)                           state_d = S_RSP;
          else if (remain_q == 1 && !edge_ph_q)  state_d = S_WR_AW;
          else                                   state_d = S_RD_AR;
        end
      S_WR_AW: if (aw_hs) state_d = S_WR_W;
      S_WR_W:  if (wbeat && beats_q == 1) state_d = S_WR_B;
      S_WR_B:
        if (bhs) state_d = (b_resp != 2'd0 || remain_q == '0) ? S_RSP : S_WR_AW;
      S_RSP:   if (rsp_ready) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // Control and address registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      smp_addr_q <= '0;
      cnt_addr_q <= '0;
      remain_q   <= '0;
      ndata_q    <= '0;
      nbins_q    <= '0;
      idx_q      <= '0;
      beats_q    <= '0;
      edge_ph_q  <= 1'b0;
      err_q      <= 1'b0;
      code_q     <= ST_OK;
    end else begin
      if (acc) begin
        code_q     <= bad_len ? ST_BAD_LEN : (bad_bins ? ST_BAD_BINS : ST_OK);
        addr_q     <= cmd.edge_addr;
        smp_addr_q <= cmd.smp_addr;
        cnt_addr_q <= cmd.cnt_addr;
        ndata_q    <= cmd.ndata;
        nbins_q    <= (BIN_W+1)'(cmd.nbins);
        remain_q   <= cmd.nbins - 1'b1;
        idx_q      <= '0;
        edge_ph_q  <= 1'b1;
        err_q      <= 1'b0;
      end
      if (ar_hs || aw_hs) beats_q <= blen;
      if (rbeat) begin
        addr_q   <= addr_q + 32'd4;
        remain_q <= remain_q - 1'b1;
        idx_q    <= idx_q + 1'b1;
        if (r_resp != 2'd0) err_q <= 1'b1;
        if (r_last) begin
          if (rd_fail) begin
            code_q <= ST_BUS_ERR;
          end else if (remain_q == 1) begin
            idx_q <= '0;
            if (edge_ph_q) begin
              edge_ph_q <= 1'b0;
              addr_q    <= smp_addr_q;
              remain_q  <= ndata_q;
            end else begin
              addr_q    <= cnt_addr_q;
              remain_q  <= LEN_W'(nbins_q);
            end
          end
        end
      end
      if (wbeat) begin
        addr_q   <= addr_q + 32'd4;
        remain_q <= remain_q - 1'b1;
        idx_q    <= idx_q + 1'b1;
        beats_q  <= beats_q - 1'b1;
      end
      if (bhs && b_resp != 2'd0) code_q <= ST_BUS_ERR;
    end
  end

  // Edge and count storage
  always_ff @(posedge clk) begin
    if (rbeat && edge_ph_q) edges_q[idx_q] <= r_data;
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      for (int i = 0; i < MAX_BINS; i++) cnt_q[i] <= '0;
    end else if (rbeat && !edge_ph_q && !rd_fail) begin
      cnt_q[bin] <= cnt_q[bin] + 1'b1;
    end
  end

  assign cmd_ready = (state_q == S_IDLE);
  assign rsp_valid = (state_q == S_RSP);
  assign rsp_data  = {30'd0, code_q};
  assign ar_valid  = (state_q == S_RD_AR);
  assign ar_addr   = addr_q;
  assign ar_len    = 8'(blen - 1'b1);
  assign r_ready   = (state_q == S_RD_R);
  assign aw_valid  = (state_q == S_WR_AW);
  assign aw_addr   = addr_q;
  assign aw_len    = 8'(blen - 1'b1);
  assign w_valid   = (state_q == S_WR_W);
  assign w_data    = 32'(cnt_q[idx_q]);
  assign w_last    = (beats_q == 1);
  assign b_ready   = (state_q == S_WR_B);
endmodule

// File: rtl/hist_accel_chk.sv
module hist_accel_chk #(
  parameter int MAX_NDATA = 4096,
  parameter int MAX_BINS  = 64,
  parameter int MAX_BURST = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         cmd_ready,
  input logic [127:0] cmd_data,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [31:0]  rsp_data,
  input logic         ar_valid,
  input logic         ar_ready,
  input logic [31:0]  ar_addr,
  input logic [7:0]   ar_len,
  input logic         aw_valid,
  input logic         aw_ready,
  input logic [31:0]  aw_addr,
  input logic [7:0]   aw_len
);
  logic [31:0] nd, nb;
  assign nd = {16'd0, cmd_data[111:96]};
  assign nb = {16'd0, cmd_data[127:112]};

  assert_busy_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ready, rsp_valid, ar_valid, aw_valid}));

  assert_len_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (nd == 0 || nd > MAX_NDATA))
      |=> (rsp_valid && rsp_data == 32'd1));

  assert_bins_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && nd != 0 && nd <= MAX_NDATA && (nb < 2 || nb > MAX_BINS))
      |=> (rsp_valid && rsp_data == 32'd2));

  assert_rd_burst_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> (32'(ar_len) < MAX_BURST));

  assert_wr_burst_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> (32'(aw_len) < MAX_BURST));

  assert_rd_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> ({20'd0, ar_addr[11:0]} + ({24'd0, ar_len} + 32'd1) * 32'd4 <= 32'd4096));

  assert_wr_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> ({20'd0, aw_addr[11:0]} + ({24'd0, aw_len} + 32'd1) * 32'd4 <= 32'd4096));

  assert_ar_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr) && $stable(ar_len)));

  assert_aw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && !aw_ready) |=> (aw_valid && $stable(aw_addr) && $stable(aw_len)));

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind hist_accel hist_accel_chk #(
  .MAX_NDATA(MAX_NDATA), .MAX_BINS(MAX_BINS), .MAX_BURST(MAX_BURST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .ar_valid(ar_valid), .ar_ready(ar_ready),
  .ar_addr(ar_addr), .ar_len(ar_len), .aw_valid(aw_valid),
  .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len)
);

// File: tb/tb_hist_accel.sv
`timescale 1ns/1ps
module tb_hist_accel;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, rsp_valid, rsp_ready;
  logic [127:0] cmd_data;
  logic [31:0] rsp_data;
  logic ar_valid, ar_ready, r_valid, r_ready, r_last;
  logic [31:0] ar_addr, r_data;
  logic [7:0] ar_len, aw_len;
  logic [1:0] r_resp, b_resp;
  logic aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready;
  logic [31:0] aw_addr, w_data;

  hist_accel dut (.*);

  int total = 0, bad = 0;
  logic [31:0] mem [8192];

  // Memory model
  logic rd_busy, wr_busy, rd_err_en, wr_err_en;
  logic [31:0] rd_addr, wr_addr, rd_err_addr;
  logic [8:0] rd_left;
  assign ar_ready = !rd_busy;
  assign r_valid  = rd_busy;
  assign r_data   = mem[rd_addr[14:2]];
  assign r_last   = (rd_left == 9'd1);
  assign r_resp   = (rd_err_en && rd_addr == rd_err_addr) ? 2'd2 : 2'd0;
  assign aw_ready = !wr_busy && !b_valid;
  assign w_ready  = wr_busy;
  assign b_resp   = wr_err_en ? 2'd2 : 2'd0;

  always @(posedge clk) begin
    if (!rst_n) rd_busy <= 1'b0;
    else if (ar_valid && ar_ready) begin
      rd_busy <= 1'b1; rd_addr <= ar_addr; rd_left <= 9'(ar_len) + 9'd1;
    end else if (r_valid && r_ready) begin
      rd_addr <= rd_addr + 32'd4; rd_left <= rd_left - 9'd1;
      if (rd_left == 9'd1) rd_busy <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin wr_busy <= 1'b0; b_valid <= 1'b0; end
    else begin
      if (aw_valid && aw_ready) begin wr_busy <= 1'b1; wr_addr <= aw_addr; end
      if (w_valid && w_ready) begin
        mem[wr_addr[14:2]] <= w_data; wr_addr <= wr_addr + 32'd4;
        if (w_last) begin wr_busy <= 1'b0; b_valid <= 1'b1; end
      end
      if (b_valid && b_ready) b_valid <= 1'b0;
    end
  end

  // Handshake monitor
  int cyc = 0, acc_cyc = 0, b_cyc = 0, ar_n = 0, aw_n = 0, rd_beats = 0, wr_beats = 0, burst_bad = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cmd_valid && cmd_ready) acc_cyc <= cyc;
    if (b_valid && b_ready) b_cyc <= cyc;
    if (ar_valid && ar_ready) begin
      ar_n <= ar_n + 1;
      if (ar_len > 8'd15 || 32'(ar_addr[11:0]) + (32'(ar_len) + 1) * 4 > 4096) burst_bad <= burst_bad + 1;
    end
    if (aw_valid && aw_ready) begin
      aw_n <= aw_n + 1;
      if (aw_len > 8'd15 || 32'(aw_addr[11:0]) + (32'(aw_len) + 1) * 4 > 4096) burst_bad <= burst_bad + 1;
    end
    if (r_valid && r_ready) rd_beats <= rd_beats + 1;
    if (w_valid && w_ready) wr_beats <= wr_beats + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic real sp2r(input logic [31:0] b);
    logic [10:0] e;
    if (b[30:23] == 8'd0) return 0.0;
    e = 11'(b[30:23]) + 11'd896;
    return $bitstoreal({b[31], e, b[22:0], 29'd0});
  endfunction

  function automatic logic [31:0] r2sp(input real r);
    logic [63:0] d;
    logic [10:0] e;
    if (r == 0.0) return 32'd0;
    d = $realtobits(r);
    e = d[62:52] - 11'd896;
    return {d[63], e[7:0], d[51:29]};
  endfunction

  function automatic bit is_nan(input logic [31:0] b);
    return b[30:23] == 8'hFF && b[22:0] != 0;
  endfunction

  function automatic int widx(input logic [31:0] a, input int k);
    return int'(a[14:2]) + k;
  endfunction

  int exp_cnt [64];

  task automatic calc_expect(input logic [31:0] sa, ea, input int nd, nb);
    for (int i = 0; i < 64; i++) exp_cnt[i] = 0;
    for (int k = 0; k < nd; k++) begin
      logic [31:0] s;
      int b;
      s = mem[widx(sa, k)];
      if (is_nan(s)) b = nb - 1;
      else begin
        b = 0;
        while (b < nb - 1 && sp2r(s) >= sp2r(mem[widx(ea, b)])) b++;
      end
      exp_cnt[b]++;
    end
  endtask

  task automatic check_counts(input logic [31:0] ca, input int nb, input string req);
    for (int i = 0; i < nb; i++)
      chk(mem[widx(ca, i)] == 32'(exp_cnt[i]), req, mem[widx(ca, i)], exp_cnt[i]);
  endtask

  // Runs one command; returns status and the cycle the status first showed
  task automatic run_cmd(input logic [31:0] sa, ea, ca, input int nd, nb,
                         output logic [31:0] st, output int seen);
    int t;
    @(negedge clk);
    cmd_data  = {16'(nb), 16'(nd), ca, ea, sa};
    cmd_valid = 1'b1;
    t = 0;
    while (!cmd_ready && t < 1000) begin @(negedge clk); t++; end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!rsp_valid ? !cmd_ready : 1'b1, "R1 busy stall", cmd_ready, 0);
    t = 0;
    while (!rsp_valid && t < 20000) begin @(negedge clk); t++; end
    seen = cyc;
    st = rsp_data;
    repeat (2) @(negedge clk);
    chk(rsp_valid && rsp_data == st && !cmd_ready, "R12 hold", rsp_data, st);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic load_basic();
    logic [31:0] s [10];
    s = '{32'hC2C80000, 32'hBF800000, 32'h3F000000, 32'h3F800000, 32'h40000000,
          32'h40200000, 32'h42C80000, 32'h7FC00000, 32'hBFC00000, 32'h00000000};
    for (int k = 0; k < 10; k++) mem[widx(32'h100, k)] = s[k];
    mem[widx(32'h200, 0)] = 32'hBF800000;
    mem[widx(32'h200, 1)] = 32'h3F800000;
    mem[widx(32'h200, 2)] = 32'h40200000;
    for (int i = 0; i < 5; i++) mem[widx(32'h300, i)] = 32'hDEAD_BEEF;
  endtask

  task automatic t_reset();
    chk(cmd_ready, "R1 reset ready", cmd_ready, 1);
    chk(!rsp_valid && !ar_valid && !aw_valid && !w_valid, "R1 reset idle",
        {rsp_valid, ar_valid, aw_valid, w_valid}, 0);
  endtask

  task automatic t_basic();
    logic [31:0] st; int seen, ar0, aw0, rb0, wb0;
    load_basic();
    ar0 = ar_n; aw0 = aw_n; rb0 = rd_beats; wb0 = wr_beats;
    run_cmd(32'h100, 32'h200, 32'h300, 10, 4, st, seen);
    chk(st == 0, "R10 status ok", st, 0);
    chk(seen - b_cyc == 1, "R10 status latency", seen - b_cyc, 1);
    calc_expect(32'h100, 32'h200, 10, 4);
    chk(exp_cnt[0] == 2 && exp_cnt[1] == 3 && exp_cnt[3] == 3, "R6 model sanity", exp_cnt[3], 3);
    check_counts(32'h300, 4, "R5 R6 counts");
    chk(rd_beats - rb0 == 13, "R4 read beats", rd_beats - rb0, 13);
    chk(wr_beats - wb0 == 4, "R7 write beats", wr_beats - wb0, 4);
    chk(mem[widx(32'h300, 4)] == 32'hDEAD_BEEF, "R7 sentinel", mem[widx(32'h300, 4)], 32'hDEAD_BEEF);
    chk(burst_bad == 0, "R9 bursts", burst_bad, 0);
    run_cmd(32'h100, 32'h200, 32'h300, 10, 4, st, seen);
    check_counts(32'h300, 4, "R8 counts cleared");
  endtask

  task automatic t_reject(input int nd, nb, input logic [31:0] code, input string req);
    logic [31:0] st; int seen, ar0, aw0;
    ar0 = ar_n; aw0 = aw_n;
    run_cmd(32'h100, 32'h200, 32'h300, nd, nb, st, seen);
    chk(st == code, req, st, code);
    chk(seen - acc_cyc == 1, req, seen - acc_cyc, 1);
    chk(ar_n == ar0 && aw_n == aw0, req, ar_n - ar0 + aw_n - aw0, 0);
  endtask

  task automatic t_boundary();
    logic [31:0] st; int seen, rb0, wb0;
    for (int i = 0; i < 63; i++) mem[widx(32'h2000, i)] = r2sp(real'(i - 31));
    for (int k = 0; k < 40; k++) mem[widx(32'h0FE0, k)] = r2sp(real'((k * 13) % 90 - 45) + 0.5);
    rb0 = rd_beats; wb0 = wr_beats;
    run_cmd(32'h0FE0, 32'h2000, 32'h3000, 40, 64, st, seen);
    chk(st == 0, "R10 boundary status", st, 0);
    calc_expect(32'h0FE0, 32'h2000, 40, 64);
    check_counts(32'h3000, 64, "R5 64 bins");
    chk(rd_beats - rb0 == 103, "R4 boundary reads", rd_beats - rb0, 103);
    chk(wr_beats - wb0 == 64, "R7 boundary writes", wr_beats - wb0, 64);
    chk(burst_bad == 0, "R9 page and length", burst_bad, 0);
  endtask

  task automatic t_full();
    logic [31:0] st; int seen;
    for (int k = 0; k < 4096; k++)
      mem[widx(32'h0, k)] = r2sp((k % 2 == 1) ? -real'(k + 1) : real'(k + 1));
    mem[widx(32'h4000, 0)] = 32'h0;
    run_cmd(32'h0, 32'h4000, 32'h5000, 4096, 2, st, seen);
    chk(st == 0, "R2 max ndata accepted", st, 0);
    calc_expect(32'h0, 32'h4000, 4096, 2);
    check_counts(32'h5000, 2, "R5 two bins full");
    chk(burst_bad == 0, "R9 long run", burst_bad, 0);
  endtask

  task automatic t_rd_err();
    logic [31:0] st; int seen, aw0;
    load_basic();
    rd_err_addr = 32'h10C; rd_err_en = 1'b1; aw0 = aw_n;
    run_cmd(32'h100, 32'h200, 32'h300, 10, 4, st, seen);
    rd_err_en = 1'b0;
    chk(st == 3, "R11 read error", st, 3);
    chk(aw_n == aw0, "R11 no writes", aw_n - aw0, 0);
  endtask

  task automatic t_wr_err();
    logic [31:0] st; int seen, aw0;
    load_basic();
    wr_err_en = 1'b1; aw0 = aw_n;
    run_cmd(32'h100, 32'h200, 32'h300, 10, 20, st, seen);
    wr_err_en = 1'b0;
    chk(st == 3, "R11 write error", st, 3);
    chk(aw_n - aw0 == 1, "R11 write abort", aw_n - aw0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0; rsp_ready = 1'b0;
    rd_err_en = 1'b0; wr_err_en = 1'b0; rd_err_addr = '0;
    for (int i = 0; i < 8192; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_reject(0, 4, 1, "R2 zero ndata");
    t_reject(4097, 4, 1, "R2 large ndata");
    t_reject(10, 1, 2, "R3 few bins");
    t_reject(10, 65, 2, "R3 many bins");
    t_reject(0, 1, 1, "R3 both bad");
    t_boundary();
    t_full();
    t_rd_err();
    t_wr_err();
    t_basic();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule